// File: doc/BRIEF.md
# MMU Control Register Bank with Unified TLB Load

This block holds the software-visible state that sits in front of a memory management unit's translation hardware. It keeps three staging registers that describe one page-table entry (a high word carrying the virtual page number and address-space identifier, a low word carrying the physical page number and attribute flags, and a small assistance word). It also keeps a control register whose upper bits hold three 6-bit TLB pointer fields. Each register applies its own keep-mask to every value written to it.

The block owns a 64-entry unified TLB array and the valid flags of a 4-entry instruction TLB. A one-cycle load command copies the staged entry into the unified entry chosen by the replace counter field. A control write with the flush bit set clears every valid flag in both TLBs in the same clock edge. The instruction TLB has a small address-array write port and a read port. Combinational read ports let the surrounding logic fetch any register or TLB entry.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero, and every unified and instruction TLB entry reads zero on its read port.
- R2: A register write with select code 0 (entry-high) stores the written value ANDed with 0xFFFFFCFF, and a read with select 0 returns it.
- R3: A register write with select code 1 (entry-low) stores the value ANDed with 0x1FFFFDFF, and a read with select 1 returns it.
- R4: A register write with select code 2 (assistance) keeps only bits [3:0], and a read with select 2 returns them zero-extended.
- R5: A register write with select code 3 (control) captures the replace counter from bits [15:10], the replace boundary from [23:18] and the LRU pointer from [31:26], and stores the rest ANDed with 0x00000301. A read with select 3 returns the stored bits ORed with the three fields at those positions, so it equals the written value ANDed with 0xFCFCFF01.
- R6: A control write with bit 2 set clears the valid flag (flag bit 8) of all unified and all instruction TLB entries at that clock edge. Every other field of every entry is kept. The flush also wins over a load command or an instruction-TLB write in the same cycle.
- R7: The load command writes unified entry [replace counter]. It takes VPN from entry-high[31:10], ASID from entry-high[7:0], PPN from entry-low[28:10], flags from entry-low[8:0] and the extra field from assistance[3:0]. Flags are stored verbatim: valid 0x100, user 0x40, writable 0x20, size 0x90 (1K 0x00, 4K 0x10, 64K 0x80, 1M 0x90), cacheable 0x08, dirty 0x04, share 0x02, write-through 0x01. The unified read port gives high = VPN<<10 | valid<<8 | ASID, low = PPN<<10 | flags, extra = extra field. No other entry changes.
- R8: The load command does not change the control register read value or any instruction TLB entry.
- R9: When a load command and a register write occur in the same cycle, both take effect. The load uses the register values from before the write, including the replace counter.
- R10: An instruction TLB write to entry [index] keeps VPN from bits [31:10], valid from bit 8 and ASID from bits [7:0]. Its read port returns VPN<<10 | valid<<8 | ASID, and other entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 high, 1 low, 2 assistance, 3 control |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_sel | input | 2 | Register read select, same coding |
| reg_rd_data | output | 32 | Selected register value |
| tlb_load | input | 1 | Copy staged entry into unified TLB |
| utlb_rd_idx | input | UIDX_W (6) | Unified TLB read index |
| utlb_rd_hi | output | 32 | Unified entry address word |
| utlb_rd_lo | output | 32 | Unified entry data word |
| utlb_rd_extra | output | 4 | Unified entry extra field |
| itlb_wr_en | input | 1 | Instruction TLB address-array write strobe |
| itlb_wr_idx | input | IIDX_W (2) | Instruction TLB write index |
| itlb_wr_data | input | 32 | Instruction TLB write value |
| itlb_rd_idx | input | IIDX_W (2) | Instruction TLB read index |
| itlb_rd_data | output | 32 | Instruction TLB entry address word |

## Verification
The properties assume that the select inputs and write data are defined, two-state values whenever their strobes are high. They also assume a write strobe is a one-cycle pulse sampled at the rising edge, because each property checks the state one edge after the strobe. The bench drives every input on the falling edge and holds it for one full cycle. It returns strobes to zero and never leaves a select or data input unknown. Same-cycle combinations of load, control write, flush and instruction-TLB write occur only in directed steps whose expected values account for the ordering those properties describe.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned PTR_W    = 6;
   localparam int unsigned VPN_W    = 22;
   localparam int unsigned PPN_W    = 19;
   localparam int unsigned ASID_W   = 8;
   localparam int unsigned FLAG_W   = 9;
   localparam int unsigned EXTRA_W  = 4;

   localparam logic [WORD_W-1:0] HI_KEEP   = 32'hFFFF_FCFF;
   localparam logic [WORD_W-1:0] LO_KEEP   = 32'h1FFF_FDFF;
   localparam logic [WORD_W-1:0] AUX_KEEP  = 32'h0000_000F;
   localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h0000_0301;

   localparam int unsigned FLUSH_BIT = 2;
   localparam int unsigned RC_LSB    = 10;
   localparam int unsigned RB_LSB    = 18;
   localparam int unsigned LRU_LSB   = 26;
   localparam int unsigned VALID_BIT = 8;

   typedef enum logic [1:0] {
      SEL_HI   = 2'd0,
      SEL_LO   = 2'd1,
      SEL_AUX  = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [VPN_W-1:0]   vpn;
      logic [ASID_W-1:0]  asid;
      logic [PPN_W-1:0]   ppn;
      logic [FLAG_W-1:0]  flags;
      logic [EXTRA_W-1:0] extra;
   } utlb_ent_t;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic              valid;
   } itlb_ent_t;
endpackage

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
   import mmu_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] hi_q,
   output logic [WORD_W-1:0] lo_q,
   output logic [WORD_W-1:0] aux_q,
   output logic [WORD_W-1:0] ctrl_q,
   output logic [PTR_W-1:0]  rc_q,
   output logic [PTR_W-1:0]  rb_q,
   output logic [PTR_W-1:0]  lru_q,
   output logic              flush
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         aux_q  <= '0;
         ctrl_q <= '0;
         rc_q   <= '0;
         rb_q   <= '0;
         lru_q  <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            SEL_HI:   hi_q  <= wr_data & HI_KEEP;
            SEL_LO:   lo_q  <= wr_data & LO_KEEP;
            SEL_AUX:  aux_q <= wr_data & AUX_KEEP;
            default: begin
               ctrl_q <= wr_data & CTRL_KEEP;
               rc_q   <= wr_data[RC_LSB  +: PTR_W];
               rb_q   <= wr_data[RB_LSB  +: PTR_W];
               lru_q  <= wr_data[LRU_LSB +: PTR_W];
            end
         endcase
      end
   end

   assign flush = wr_en && (wr_sel == SEL_CTRL) && wr_data[FLUSH_BIT];
endmodule

// File: rtl/mmu_utlb_store.sv
module mmu_utlb_store
   import mmu_regs_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic [WORD_W-1:0] hi,
   input  logic [WORD_W-1:0] lo,
   input  logic [WORD_W-1:0] aux,
   input  logic              flush,
   input  logic [IDX_W-1:0]  rd_idx,
   output utlb_ent_t         rd_ent,
   output logic [DEPTH-1:0]  valid_vec
);
   utlb_ent_t fill;
   utlb_ent_t view [DEPTH];

   always_comb begin
      fill.vpn   = hi[WORD_W-1 -: VPN_W];
      fill.asid  = hi[ASID_W-1:0];
      fill.ppn   = lo[RC_LSB +: PPN_W];
      fill.flags = lo[FLAG_W-1:0];
      fill.extra = aux[EXTRA_W-1:0];
   end

   logic unused_bits;
   assign unused_bits = ^{hi[9:8], lo[31:29], lo[9], aux[31:4]};

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      utlb_ent_t ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else begin
            if (load && (load_idx == IDX_W'(e)))
               ent_q <= fill;
            if (flush)
               ent_q.flags[VALID_BIT] <= 1'b0;
         end
      end
      assign view[e]      = ent_q;
      assign valid_vec[e] = ent_q.flags[VALID_BIT];
   end

   assign rd_ent = view[rd_idx];
endmodule

// File: rtl/mmu_itlb_store.sv
module mmu_itlb_store
   import mmu_regs_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              flush,
   input  logic [IDX_W-1:0]  rd_idx,
   output itlb_ent_t         rd_ent,
   output logic [DEPTH-1:0]  valid_vec
);
   itlb_ent_t fill;
   itlb_ent_t view [DEPTH];

   always_comb begin
      fill.vpn   = wr_data[WORD_W-1 -: VPN_W];
      fill.asid  = wr_data[ASID_W-1:0];
      fill.valid = wr_data[VALID_BIT];
   end

   logic unused_bit9;
   assign unused_bit9 = wr_data[9];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      itlb_ent_t ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else begin
            if (wr_en && (wr_idx == IDX_W'(e)))
               ent_q <= fill;
            if (flush)
               ent_q.valid <= 1'b0;
         end
      end
      assign view[e]      = ent_q;
      assign valid_vec[e] = ent_q.valid;
   end

   assign rd_ent = view[rd_idx];
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
   import mmu_regs_pkg::*;
#(
   parameter int UTLB_DEPTH = 64,
   parameter int ITLB_DEPTH = 4,
   localparam int UIDX_W = $clog2(UTLB_DEPTH),
   localparam int IIDX_W = $clog2(ITLB_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [31:0]       reg_wr_data,
   input  logic [1:0]        reg_rd_sel,
   output logic [31:0]       reg_rd_data,
   input  logic              tlb_load,
   input  logic [UIDX_W-1:0] utlb_rd_idx,
   output logic [31:0]       utlb_rd_hi,
   output logic [31:0]       utlb_rd_lo,
   output logic [3:0]        utlb_rd_extra,
   input  logic              itlb_wr_en,
   input  logic [IIDX_W-1:0] itlb_wr_idx,
   input  logic [31:0]       itlb_wr_data,
   input  logic [IIDX_W-1:0] itlb_rd_idx,
   output logic [31:0]       itlb_rd_data
);
   if (UTLB_DEPTH < 2 || UTLB_DEPTH > (1 << PTR_W) ||
       (UTLB_DEPTH & (UTLB_DEPTH - 1)) != 0) begin : g_bad_utlb
      $error("UTLB_DEPTH must be a power of two from 2 to 64");
   end
   if (ITLB_DEPTH < 2 || (ITLB_DEPTH & (ITLB_DEPTH - 1)) != 0) begin : g_bad_itlb
      $error("ITLB_DEPTH must be a power of two of at least 2");
   end

   logic [WORD_W-1:0]     hi_q, lo_q, aux_q, ctrl_q, ctrl_rd;
   logic [PTR_W-1:0]      rc_q, rb_q, lru_q;
   logic                  flush;
   logic [UTLB_DEPTH-1:0] uvalid;
   logic [ITLB_DEPTH-1:0] ivalid;
   utlb_ent_t             u_ent;
   itlb_ent_t             i_ent;

   mmu_reg_bank u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_sel  (reg_wr_sel),
      .wr_data (reg_wr_data),
      .hi_q    (hi_q),
      .lo_q    (lo_q),
      .aux_q   (aux_q),
      .ctrl_q  (ctrl_q),
      .rc_q    (rc_q),
      .rb_q    (rb_q),
      .lru_q   (lru_q),
      .flush   (flush)
   );

   mmu_utlb_store #(.DEPTH(UTLB_DEPTH)) u_utlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tlb_load),
      .load_idx  (rc_q[UIDX_W-1:0]),
      .hi        (hi_q),
      .lo        (lo_q),
      .aux       (aux_q),
      .flush     (flush),
      .rd_idx    (utlb_rd_idx),
      .rd_ent    (u_ent),
      .valid_vec (uvalid)
   );

   mmu_itlb_store #(.DEPTH(ITLB_DEPTH)) u_itlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (itlb_wr_en),
      .wr_idx    (itlb_wr_idx),
      .wr_data   (itlb_wr_data),
      .flush     (flush),
      .rd_idx    (itlb_rd_idx),
      .rd_ent    (i_ent),
      .valid_vec (ivalid)
   );

   always_comb begin
      ctrl_rd = ctrl_q;
      ctrl_rd[RC_LSB  +: PTR_W] = rc_q;
      ctrl_rd[RB_LSB  +: PTR_W] = rb_q;
      ctrl_rd[LRU_LSB +: PTR_W] = lru_q;
   end

   always_comb begin
      unique case (reg_rd_sel)
         SEL_HI:  reg_rd_data = hi_q;
         SEL_LO:  reg_rd_data = lo_q;
         SEL_AUX: reg_rd_data = aux_q;
         default: reg_rd_data = ctrl_rd;
      endcase
   end

   assign utlb_rd_hi    = {u_ent.vpn, 1'b0, u_ent.flags[VALID_BIT], u_ent.asid};
   assign utlb_rd_lo    = {3'b000, u_ent.ppn, 1'b0, u_ent.flags};
   assign utlb_rd_extra = u_ent.extra;
   assign itlb_rd_data  = {i_ent.vpn, 1'b0, i_ent.valid, i_ent.asid};
endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk
   import mmu_regs_pkg::*;
#(
   parameter int UTLB_DEPTH = 64,
   parameter int ITLB_DEPTH = 4,
   localparam int UIDX_W = $clog2(UTLB_DEPTH)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr_en,
   input logic [1:0]            reg_wr_sel,
   input logic [31:0]           reg_wr_data,
   input logic                  tlb_load,
   input logic                  itlb_wr_en,
   input logic [31:0]           hi_q,
   input logic [31:0]           lo_q,
   input logic [PTR_W-1:0]      rc_q,
   input logic [31:0]           ctrl_rd,
   input logic [UTLB_DEPTH-1:0] uvalid,
   input logic [ITLB_DEPTH-1:0] ivalid
);
   logic ctrl_wr, flush_req;
   assign ctrl_wr   = reg_wr_en && (reg_wr_sel == SEL_CTRL);
   assign flush_req = ctrl_wr && reg_wr_data[FLUSH_BIT];

   // R2
   hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_sel == SEL_HI) |=> (hi_q == ($past(reg_wr_data) & 32'hFFFF_FCFF)));

   // R5
   ctrl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ctrl_rd == ($past(reg_wr_data) & 32'hFCFC_FF01)));

   // R6
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> (uvalid == '0 && ivalid == '0));

   // R7
   load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_load && !flush_req) |=> (uvalid[$past(rc_q[UIDX_W-1:0])] == $past(lo_q[VALID_BIT])));

   // R8
   load_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_load && !ctrl_wr) |=> $stable(ctrl_rd));

   // R8
   load_itlb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_load && !itlb_wr_en && !flush_req) |=> $stable(ivalid));
endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk #(
   .UTLB_DEPTH (UTLB_DEPTH),
   .ITLB_DEPTH (ITLB_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_sel  (reg_wr_sel),
   .reg_wr_data (reg_wr_data),
   .tlb_load    (tlb_load),
   .itlb_wr_en  (itlb_wr_en),
   .hi_q        (hi_q),
   .lo_q        (lo_q),
   .rc_q        (rc_q),
   .ctrl_rd     (ctrl_rd),
   .uvalid      (uvalid),
   .ivalid      (ivalid)
);

// File: tb/tb_mmu_ctrl_regs.sv
module tb_mmu_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_wr_sel = '0;
   logic [31:0] reg_wr_data = '0;
   logic [1:0]  reg_rd_sel = '0;
   logic [31:0] reg_rd_data;
   logic        tlb_load = 1'b0;
   logic [5:0]  utlb_rd_idx = '0;
   logic [31:0] utlb_rd_hi, utlb_rd_lo;
   logic [3:0]  utlb_rd_extra;
   logic        itlb_wr_en = 1'b0;
   logic [1:0]  itlb_wr_idx = '0;
   logic [31:0] itlb_wr_data = '0;
   logic [1:0]  itlb_rd_idx = '0;
   logic [31:0] itlb_rd_data;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   mmu_ctrl_regs dut (.*);

   // {select, write data, expected read-back}
   localparam int NV = 9;
   localparam logic [65:0] VEC [NV] = '{
      {2'd0, 32'hFFFF_FFFF, 32'hFFFF_FCFF},
      {2'd0, 32'h1234_5678, 32'h1234_5478},
      {2'd1, 32'hFFFF_FFFF, 32'h1FFF_FDFF},
      {2'd1, 32'hA5A5_A3A5, 32'h05A5_A1A5},
      {2'd2, 32'hFFFF_FFFF, 32'h0000_000F},
      {2'd2, 32'h1234_5676, 32'h0000_0006},
      {2'd3, 32'hFFFF_FFFB, 32'hFCFC_FF01},
      {2'd3, 32'h0410_2C05, 32'h0410_2C01},
      {2'd3, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic pulse_load();
      @(negedge clk);
      tlb_load = 1'b1;
      @(negedge clk);
      tlb_load = 1'b0;
   endtask

   task automatic itlb_wr(input logic [1:0] idx, input logic [31:0] data);
      @(negedge clk);
      itlb_wr_en = 1'b1; itlb_wr_idx = idx; itlb_wr_data = data;
      @(negedge clk);
      itlb_wr_en = 1'b0;
   endtask

   task automatic reg_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
      reg_rd_sel = sel; #1;
      check(tag, reg_rd_data, exp);
   endtask

   task automatic utlb_chk(input string tag, input logic [5:0] idx,
                           input logic [31:0] ehi, input logic [31:0] elo, input logic [3:0] ex);
      utlb_rd_idx = idx; #1;
      check({tag, " hi"}, utlb_rd_hi, ehi);
      check({tag, " lo"}, utlb_rd_lo, elo);
      check({tag, " extra"}, {28'd0, utlb_rd_extra}, {28'd0, ex});
   endtask

   task automatic itlb_chk(input string tag, input logic [1:0] idx, input logic [31:0] exp);
      itlb_rd_idx = idx; #1;
      check(tag, itlb_rd_data, exp);
   endtask

   function automatic string sel_tag(input logic [1:0] s);
      case (s)
         2'd0: return "R2";
         2'd1: return "R3";
         2'd2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic reset_all_chk(input string tag);
      for (int s = 0; s < 4; s++) reg_chk({tag, " reg"}, 2'(s), 32'h0);
      for (int u = 0; u < 64; u += 9) utlb_chk({tag, " utlb"}, 6'(u), 32'h0, 32'h0, 4'h0);
      utlb_chk({tag, " utlb63"}, 6'd63, 32'h0, 32'h0, 4'h0);
      for (int i = 0; i < 4; i++) itlb_chk({tag, " itlb"}, 2'(i), 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      reset_all_chk("R1");

      // R2 R3 R4 R5: mask table
      for (int v = 0; v < NV; v++) begin
         reg_wr(VEC[v][65:64], VEC[v][63:32]);
         reg_chk(sel_tag(VEC[v][65:64]), VEC[v][65:64], VEC[v][31:0]);
      end

      // R7: load into entry 5 with 1M size and valid flags
      reg_wr(2'd0, 32'hABCD_E7FF);
      reg_wr(2'd1, 32'h0765_4590);
      reg_wr(2'd2, 32'h0000_0005);
      reg_wr(2'd3, 32'h0000_1400);
      pulse_load();
      utlb_chk("R7 load e5", 6'd5, 32'hABCD_E5FF, 32'h0765_4590, 4'h5);
      utlb_chk("R7 neighbour e4", 6'd4, 32'h0, 32'h0, 4'h0);
      // R8: control unchanged by load
      reg_chk("R8 ctrl", 2'd3, 32'h0000_1400);

      // R10: instruction TLB writes
      itlb_wr(2'd1, 32'h1234_0DAB);
      itlb_wr(2'd2, 32'h0000_0100);
      itlb_chk("R10 itlb1", 2'd1, 32'h1234_0DAB);
      itlb_chk("R10 itlb2", 2'd2, 32'h0000_0100);
      itlb_chk("R10 itlb0", 2'd0, 32'h0);
      pulse_load();
      itlb_chk("R8 itlb1", 2'd1, 32'h1234_0DAB);

      // R9: load with same-cycle high write uses old high value
      reg_wr(2'd3, 32'h0000_1C00);
      @(negedge clk);
      tlb_load = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 32'h2222_0000;
      @(negedge clk);
      tlb_load = 1'b0; reg_wr_en = 1'b0;
      utlb_chk("R9 old hi e7", 6'd7, 32'hABCD_E5FF, 32'h0765_4590, 4'h5);
      reg_chk("R9 hi written", 2'd0, 32'h2222_0000);

      // R9: load with same-cycle control write uses old counter
      @(negedge clk);
      tlb_load = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd3; reg_wr_data = 32'h0000_2400;
      @(negedge clk);
      tlb_load = 1'b0; reg_wr_en = 1'b0;
      utlb_chk("R9 old rc e7", 6'd7, 32'h2222_0100, 32'h0765_4590, 4'h5);
      utlb_chk("R9 new rc e9", 6'd9, 32'h0, 32'h0, 4'h0);
      reg_chk("R9 ctrl", 2'd3, 32'h0000_2400);

      // R6: flush clears valid in both TLBs, other fields kept
      reg_wr(2'd3, 32'h0000_2405);
      utlb_chk("R6 e5", 6'd5, 32'hABCD_E4FF, 32'h0765_4490, 4'h5);
      utlb_chk("R6 e7", 6'd7, 32'h2222_0000, 32'h0765_4490, 4'h5);
      itlb_chk("R6 itlb1", 2'd1, 32'h1234_0CAB);
      itlb_chk("R6 itlb2", 2'd2, 32'h0);
      reg_chk("R5 ctrl after flush", 2'd3, 32'h0000_2401);

      // R6: flush wins over same-cycle load and itlb write
      @(negedge clk);
      tlb_load = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd3; reg_wr_data = 32'h0000_2404;
      itlb_wr_en = 1'b1; itlb_wr_idx = 2'd3; itlb_wr_data = 32'h5555_0D11;
      @(negedge clk);
      tlb_load = 1'b0; reg_wr_en = 1'b0; itlb_wr_en = 1'b0;
      utlb_chk("R6 load+flush e9", 6'd9, 32'h2222_0000, 32'h0765_4490, 4'h5);
      itlb_chk("R6 itlbwr+flush", 2'd3, 32'h5555_0C11);

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      reset_all_chk("R1 rerun");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule